// File: doc/BRIEF.md
# Load/Store Transfer Sequencer

This block runs the single-register load and store instructions of a 32-bit pipelined core. It accepts an instruction in the execute stage and reads its transfer fields. From a base register value and an offset it forms the effective address. In that same cycle it issues any base-register update. It then runs a request/wait handshake with memory, stalling the pipeline until memory signals completion. For loads it returns the read data to the register file one cycle later.

The register file and the shifter sit outside the block. They supply the base value, the already shifted register offset and the store source value. The access address and the transfer attributes are captured in hold registers when the transfer is accepted, so they stay constant for the whole memory phase. A copy of the instruction is also kept in a shadow register, which lets the main instruction register move on during the stall.

Top module: `ldst_seq`

## Requirements
- R1: After reset the block is idle: `mem_req_n`=1, `stall`=0, `base_we`=0, `ld_we`=0.
- R2: Offset source is chosen by instruction bit 25. With bit 25=0 the offset is bits 11:0, zero-extended. With bit 25=1 it is `reg_off`. Bit 23=1 adds the offset to `base_val` and bit 23=0 subtracts it.
- R3: Pre-indexed (bit 24=1): the computed address is the access address. The base is written back only when bit 21=1.
- R4: Post-indexed (bit 24=0): the unmodified `base_val` is the access address. The computed address is always written back, whatever bit 21 holds.
- R5: Base writeback is combinational in the accept cycle (`start`=1 while idle). It has `base_waddr`=bits 19:16 and `base_wdata`=computed address. `mem_req_n` goes low in the following cycle.
- R6: During the request, `mem_dir` is 0 for a load (bit 20=1) and 1 for a store (bit 20=0). `mem_byte` equals bit 22 (1 = byte, 0 = word).
- R7: `stall` is high from the first request cycle and stays high, with `mem_req_n` low, until a cycle in which `mem_wait`=1. `mem_addr` stays constant over that whole window.
- R8: `shadow_ir` takes the accepted instruction when the stall begins and holds it while stalled.
- R9: For a load, in the cycle after completion: `ld_we`=1, `ld_waddr`=bits 15:12 and `stall`=0. `ld_wdata` is the read data for a word. For a byte it is `rdata[7:0]` zero-extended.
- R10: For a store, `st_data` is `src_val` for a word, or `src_val[7:0]` copied into every byte lane for a byte. The block is idle again in the cycle after completion, with no load writeback.
- R11: `start` has no effect while a transfer is in progress. No base writeback occurs, and the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Execute-stage load/store present |
| instr | input | 32 | Instruction word |
| base_val | input | DW | Base register value |
| reg_off | input | DW | Shifted register offset |
| src_val | input | DW | Store source register value |
| mem_wait | input | 1 | High when memory completes the transfer |
| rdata | input | DW | Memory read data |
| mem_addr | output | DW | Held access address |
| mem_req_n | output | 1 | Active-low memory request |
| mem_dir | output | 1 | 0 load, 1 store |
| mem_byte | output | 1 | 1 byte, 0 word transfer |
| stall | output | 1 | Pipeline stall |
| base_we | output | 1 | Base register writeback enable |
| base_waddr | output | 4 | Base register index |
| base_wdata | output | DW | Updated base value |
| ld_we | output | 1 | Load data writeback enable |
| ld_waddr | output | 4 | Load destination index |
| ld_wdata | output | DW | Load writeback data |
| st_data | output | DW | Store data to memory |
| shadow_ir | output | 32 | Shadow copy of the stalled instruction |

## Verification
The bench builds the block with its default 32-bit data width. Every addressing mode, offset direction and byte-lane case is therefore visible at full width. With full 32-bit operands, address subtraction can wrap below zero, and byte zero-extension has 24 upper bits to clear. The tests vary how long memory waits, from immediate completion to several wait cycles. This exercises address and shadow stability over multi-cycle stalls, as well as `start` arriving during a transfer.

// File: rtl/ldst_seq.sv
module ldst_seq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] reg_off,
  input  logic [DW-1:0] src_val,
  input  logic          mem_wait,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] mem_addr,
  output logic          mem_req_n,
  output logic          mem_dir,
  output logic          mem_byte,
  output logic          stall,
  output logic          base_we,
  output logic [3:0]    base_waddr,
  output logic [DW-1:0] base_wdata,
  output logic          ld_we,
  output logic [3:0]    ld_waddr,
  output logic [DW-1:0] ld_wdata,
  output logic [DW-1:0] st_data,
  output logic [31:0]   shadow_ir
);
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_LDWB} state_t;
  state_t state;

  logic          accept;
  logic [DW-1:0] offset, calc_addr, acc_addr, st_next;
  logic [DW-1:0] addr_q, st_q, rd_q;
  logic          dir_q, byte_q;
  logic [3:0]    dst_q;
  logic [31:0]   shadow_q;

  assign accept    = start && (state == S_IDLE);
  assign offset    = instr[25] ? reg_off : {{(DW-12){1'b0}}, instr[11:0]};
  assign calc_addr = instr[23] ? base_val + offset : base_val - offset;
  assign acc_addr  = instr[24] ? calc_addr : base_val;
  assign st_next   = instr[22] ? {NB{src_val[7:0]}} : src_val;

  assign base_we    = accept && (!instr[24] || instr[21]);
  assign base_waddr = instr[19:16];
  assign base_wdata = calc_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      st_q     <= '0;
      rd_q     <= '0;
      dir_q    <= 1'b0;
      byte_q   <= 1'b0;
      dst_q    <= '0;
      shadow_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          addr_q   <= acc_addr;
          dir_q    <= !instr[20];
          byte_q   <= instr[22];
          dst_q    <= instr[15:12];
          st_q     <= st_next;
          shadow_q <= instr;
          state    <= S_XFER;
        end
        S_XFER: if (mem_wait) begin
          rd_q  <= byte_q ? {{(DW-8){1'b0}}, rdata[7:0]} : rdata;
          state <= dir_q ? S_IDLE : S_LDWB;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_n = (state != S_XFER);
  assign stall     = (state == S_XFER);
  assign mem_addr  = addr_q;
  assign mem_dir   = dir_q;
  assign mem_byte  = byte_q;
  assign st_data   = st_q;
  assign shadow_ir = shadow_q;
  assign ld_we     = (state == S_LDWB);
  assign ld_waddr  = dst_q;
  assign ld_wdata  = rd_q;

  p_req_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_req_n && !ld_we) |=> !mem_req_n);
  p_post_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_req_n && !ld_we && !instr[24]) |-> base_we);
  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && !mem_wait) |=> (!mem_req_n && stall && $stable(mem_addr)));
  p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && !mem_wait) |=> $stable(shadow_ir));
  p_ldwb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_wait && !mem_dir) |=> (ld_we && !stall));
  p_st_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_wait && mem_dir) |=> (mem_req_n && !ld_we));
  p_busy_nowb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n || ld_we) |-> !base_we);
endmodule

// File: tb/sim_ldst_seq.sv
module sim_ldst_seq;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0, start = 0, mem_wait = 0;
  logic [31:0] instr = '0;
  logic [DW-1:0] base_val = '0, reg_off = '0, src_val = '0, rdata = '0;
  logic [DW-1:0] mem_addr, base_wdata, ld_wdata, st_data;
  logic mem_req_n, mem_dir, mem_byte, stall, base_we, ld_we;
  logic [3:0] base_waddr, ld_waddr;
  logic [31:0] shadow_ir;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ldst_seq #(.DW(DW)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .base_val(base_val), .reg_off(reg_off), .src_val(src_val), .mem_wait(mem_wait),
    .rdata(rdata), .mem_addr(mem_addr), .mem_req_n(mem_req_n), .mem_dir(mem_dir),
    .mem_byte(mem_byte), .stall(stall), .base_we(base_we), .base_waddr(base_waddr),
    .base_wdata(base_wdata), .ld_we(ld_we), .ld_waddr(ld_waddr), .ld_wdata(ld_wdata),
    .st_data(st_data), .shadow_ir(shadow_ir));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit ld, input bit byt, input bit pre, input bit up,
      input bit wb, input bit regoff, input logic [3:0] rn, input logic [3:0] rd,
      input logic [11:0] imm);
    mk = {4'hE, 2'b01, regoff, pre, up, byt, wb, ld, rn, rd, imm};
  endfunction

  task automatic xfer(input logic [31:0] ins, input logic [DW-1:0] base, input logic [DW-1:0] roff,
      input logic [DW-1:0] src, input int waits, input logic [DW-1:0] rd, input bit poke);
    logic [DW-1:0] off, calc, acc, exp_st, exp_ld;
    bit exp_wb;
    off    = ins[25] ? roff : {{(DW-12){1'b0}}, ins[11:0]};
    calc   = ins[23] ? base + off : base - off;
    acc    = ins[24] ? calc : base;
    exp_wb = !ins[24] || ins[21];
    exp_st = ins[22] ? {4{src[7:0]}} : src;
    exp_ld = ins[22] ? {24'd0, rd[7:0]} : rd;
    @(negedge clk);
    instr = ins; base_val = base; reg_off = roff; src_val = src; start = 1; mem_wait = 0;
    #2;
    chk(ins[24] ? "R3 base_we" : "R4 base_we", {31'd0, base_we}, {31'd0, exp_wb});
    if (exp_wb) begin
      chk("R5 base_wdata R2", base_wdata, calc);
      chk("R5 base_waddr", {28'd0, base_waddr}, {28'd0, ins[19:16]});
    end
    chk("R5 no request in accept cycle", {31'd0, mem_req_n}, 32'd1);
    @(negedge clk);
    start = 0; base_val = ~base; instr = 32'hFFFF_FFFF;
    #2;
    chk("R5 request", {31'd0, mem_req_n}, 32'd0);
    chk("R7 stall", {31'd0, stall}, 32'd1);
    chk(ins[24] ? "R3 addr" : "R4 addr", mem_addr, acc);
    chk("R6 dir", {31'd0, mem_dir}, {31'd0, !ins[20]});
    chk("R6 byte", {31'd0, mem_byte}, {31'd0, ins[22]});
    chk("R8 shadow", shadow_ir, ins);
    if (!ins[20]) chk("R10 st_data", st_data, exp_st);
    for (int i = 0; i < waits; i++) begin
      if (poke && i == 0) begin
        start = 1; instr = mk(0, 0, 0, 1, 0, 0, 4'd9, 4'd9, 12'h100);
        #2;
        chk("R11 base_we while busy", {31'd0, base_we}, 32'd0);
      end
      @(negedge clk);
      start = 0;
      #2;
      chk("R7 req held", {31'd0, mem_req_n}, 32'd0);
      chk("R7 stall held", {31'd0, stall}, 32'd1);
      chk("R7 addr stable R11", mem_addr, acc);
      chk("R8 shadow held", shadow_ir, ins);
    end
    mem_wait = 1; rdata = rd;
    @(negedge clk);
    mem_wait = 0; rdata = ~rd;
    #2;
    if (ins[20]) begin
      chk("R9 ld_we", {31'd0, ld_we}, 32'd1);
      chk("R9 stall released", {31'd0, stall}, 32'd0);
      chk("R9 ld_waddr", {28'd0, ld_waddr}, {28'd0, ins[15:12]});
      chk("R9 ld_wdata", ld_wdata, exp_ld);
      @(negedge clk);
      #2;
      chk("R9 ld_we single", {31'd0, ld_we}, 32'd0);
    end else begin
      chk("R10 idle req", {31'd0, mem_req_n}, 32'd1);
      chk("R10 no ld_we", {31'd0, ld_we}, 32'd0);
      chk("R10 stall off", {31'd0, stall}, 32'd0);
    end
  endtask

  task automatic t_reset();
    #2;
    chk("R1 req_n", {31'd0, mem_req_n}, 32'd1);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 base_we", {31'd0, base_we}, 32'd0);
    chk("R1 ld_we", {31'd0, ld_we}, 32'd0);
  endtask

  task automatic t_pre_imm_load_word();
    xfer(mk(1, 0, 1, 1, 0, 0, 4'd2, 4'd3, 12'h024), 32'h0000_1000, 32'h0, 32'h0, 2, 32'hDEAD_BEEF, 0);
  endtask
  task automatic t_pre_wb_down_load_byte();
    xfer(mk(1, 1, 1, 0, 1, 0, 4'd5, 4'd7, 12'h010), 32'h0000_0008, 32'h0, 32'h0, 0, 32'h1234_56A5, 0);
  endtask
  task automatic t_post_reg_store_word();
    xfer(mk(0, 0, 0, 1, 0, 1, 4'd1, 4'd4, 12'h000), 32'h2000_0000, 32'h0000_0040, 32'hCAFE_F00D, 3, 32'h0, 1);
  endtask
  task automatic t_post_down_store_byte();
    xfer(mk(0, 1, 0, 0, 1, 1, 4'd13, 4'd6, 12'h000), 32'h0000_0100, 32'h0000_0004, 32'h0000_0077, 1, 32'h0, 0);
  endtask
  task automatic t_pre_reg_load_word_nowait();
    xfer(mk(1, 0, 1, 1, 1, 1, 4'd8, 4'd15, 12'h000), 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 0, 32'h8000_0001, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pre_imm_load_word();
    t_pre_wb_down_load_byte();
    t_post_reg_store_word();
    t_post_down_store_byte();
    t_pre_reg_load_word_nowait();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule